// File: doc/BRIEF.md
# Turn Loop Detector with Escape Manoeuvre

This block watches the motion commands a maze-exploring robot sends to its drive logic and spots when the robot keeps circling a free-standing wall. Each time the command source pulses a sample strobe, the block takes in the 3-bit motion code. It keeps a count of how many turns in a row went in the same direction. Commands that arrive without a strobe are not looked at.

When the run reaches the configured length (five by default), the block declares a loop. It raises a valid flag and sends a one-cycle request to start the external movement timer. It then presents an escape manoeuvre until the timer reports that it is done. The escape always turns away from the loop, so a robot that was circling left makes a right manoeuvre. A free-running counter decides whether the manoeuvre is a rotate (both wheels driven) or a pivot (one wheel braked), which makes the choice look random. A separate arbiter, not part of this block, decides whether the escape command reaches the motors.

Top module: `loopesc_top`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `esc_cmd` is 000 and both `esc_valid` and `timer_start` are low.
- R2: Motion codes are: 000 stop, 001 forward, 010 reverse, 011 rotate right, 100 rotate left, 101 pivot right, 110 pivot left, 111 brake. Codes 011 and 101 are right turns, and 100 and 110 are left turns. Taking RUN_LEN (default 5) same-direction turns in a row on strobe edges declares a loop.
- R3: A command present on a clock edge without `cmd_strobe` has no effect on the run count.
- R4: A turn opposite to the current run restarts the run at a count of one, in the new direction.
- R5: A strobed non-turn code (000, 001, 010, 111) clears the run count to zero.
- R6: A loop is declared at the clock edge that samples the last turn of the run. In the following cycle `esc_valid` and `timer_start` are both high, and `timer_start` stays high for exactly one cycle.
- R7: After the start cycle, `esc_valid` stays high until an edge at which `timer_done` is high. It is low in the next cycle, and a new run starts from zero. `timer_done` is ignored during the start cycle.
- R8: The escape turns opposite to the loop. A left loop gives 011 or 101, and a right loop gives 100 or 110. The choice is made by a 2-bit counter that is 0 at the first edge after reset and advances on every edge. An even value gives a rotate and an odd value gives a pivot. The value used is the one present at the declaring edge, and the code is held for the whole escape.
- R9: Whenever `esc_valid` is low, `esc_cmd` is 000.
- R10: Strobes that arrive while an escape is active are ignored and do not count toward the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 3 | Motion code from the avoidance controller |
| cmd_strobe | input | 1 | Sample `cmd_in` on this edge |
| timer_done | input | 1 | External movement timer has expired |
| esc_cmd | output | 3 | Escape motion code, 000 when idle |
| esc_valid | output | 1 | An escape manoeuvre is being requested |
| timer_start | output | 1 | One-cycle request to start the movement timer |

## Verification
The bench goes after the cases where the run count is easy to get wrong.

- **Unstrobed commands.** A block that reads `cmd_in` without the strobe would fire early when unstrobed left codes sit between strobes.
- **Direction changes.** A block that zeroes the count on a direction change, instead of restarting at one, would need one extra turn before it fires.
- **Non-turn codes.** A block that treats forward or brake as neutral would fire after a run broken by a forward code.
- **Strobes during an escape.** A block that keeps counting during an escape would declare the next loop too soon.

Loops are ended at different counter phases, so all four escape codes are seen. A design that does not invert the direction, or does not hold the code, disagrees with the cycle model on the first mismatching cycle.

// File: rtl/loopesc_pkg.sv
package loopesc_pkg;

  localparam int MOVE_W = 3;

  typedef enum logic [MOVE_W-1:0] {
    MV_STOP  = 3'd0,
    MV_FWD   = 3'd1,
    MV_BACK  = 3'd2,
    MV_ROT_R = 3'd3,
    MV_ROT_L = 3'd4,
    MV_PIV_R = 3'd5,
    MV_PIV_L = 3'd6,
    MV_BRAKE = 3'd7
  } move_e;

  typedef enum logic [3:0] {
    ST_WATCH = 4'b0000,
    ST_KICK  = 4'b0011,
    ST_HOLD  = 4'b0101
  } phase_e;

  function automatic logic is_right_turn(logic [MOVE_W-1:0] c);
    return (c == MV_ROT_R) || (c == MV_PIV_R);
  endfunction

  function automatic logic is_left_turn(logic [MOVE_W-1:0] c);
    return (c == MV_ROT_L) || (c == MV_PIV_L);
  endfunction

  // The escape heads away from the loop: a right loop gets a left manoeuvre.
  function automatic logic [MOVE_W-1:0] escape_move(logic loop_right, logic pivot);
    if (loop_right) return pivot ? MV_PIV_L : MV_ROT_L;
    else            return pivot ? MV_PIV_R : MV_ROT_R;
  endfunction

endpackage

// File: rtl/loopesc_run_counter.sv
module loopesc_run_counter
  import loopesc_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic [MOVE_W-1:0] cmd,
  output logic              hit,
  output logic              hit_right
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] run_q, next_cnt;
  logic             dir_q, turn, right, same;

  always_comb begin
    right     = is_right_turn(cmd);
    turn      = right || is_left_turn(cmd);
    same      = (run_q != '0) && (dir_q == right);
    next_cnt  = same ? CNT_W'(run_q + 1'b1) : CNT_W'(1);
    hit       = sample && turn && (next_cnt == CNT_W'(RUN_LEN));
    hit_right = right;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      dir_q <= 1'b0;
    end else if (sample) begin
      if (!turn || hit) begin
        run_q <= '0;
      end else begin
        run_q <= next_cnt;
        dir_q <= right;
      end
    end
  end

  // The stored run never reaches the declaring length: the count is cleared on the hit.
  p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run_q < CNT_W'(RUN_LEN));

endmodule

// File: rtl/loopesc_phase_ctr.sv
module loopesc_phase_ctr #(
  parameter int SEL_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic odd
);
  logic [SEL_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q + 1'b1;
  end

  assign odd = q[0];

  // The counter must step on every edge; its parity alternates.
  p_parity_toggles_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (odd != $past(odd)));

endmodule

// File: rtl/loopesc_escape_gen.sv
module loopesc_escape_gen
  import loopesc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              loop_right,
  input  logic              pivot,
  input  logic              clear,
  output logic [MOVE_W-1:0] move_q
);
  always_ff @(posedge clk) begin
    if (rst)        move_q <= MV_STOP;
    else if (load)  move_q <= escape_move(loop_right, pivot);
    else if (clear) move_q <= MV_STOP;
  end
endmodule

// File: rtl/loopesc_top.sv
module loopesc_top
  import loopesc_pkg::*;
#(
  parameter int RUN_LEN = 5,
  parameter int SEL_W   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  cmd_in,
  input  logic        cmd_strobe,
  input  logic        timer_done,
  output logic [2:0]  esc_cmd,
  output logic        esc_valid,
  output logic        timer_start
);
  phase_e state_q, state_d;
  logic   sample, hit, hit_right, pivot, clear;

  assign sample = cmd_strobe && (state_q == ST_WATCH);
  assign clear  = (state_q == ST_HOLD) && timer_done;

  loopesc_run_counter #(.RUN_LEN(RUN_LEN)) run_i (
    .clk(clk), .rst(rst), .sample(sample), .cmd(cmd_in),
    .hit(hit), .hit_right(hit_right)
  );

  loopesc_phase_ctr #(.SEL_W(SEL_W)) phase_i (
    .clk(clk), .rst(rst), .odd(pivot)
  );

  loopesc_escape_gen esc_i (
    .clk(clk), .rst(rst), .load(hit), .loop_right(hit_right),
    .pivot(pivot), .clear(clear), .move_q(esc_cmd)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WATCH: if (hit) state_d = ST_KICK;
      ST_KICK:  state_d = ST_HOLD;
      ST_HOLD:  if (timer_done) state_d = ST_WATCH;
      default:  state_d = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_WATCH;
    else     state_q <= state_d;
  end

  // Moore flags, decoded from the present state only.
  assign esc_valid   = (state_q != ST_WATCH);
  assign timer_start = (state_q == ST_KICK);

  p_start_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    timer_start |=> !timer_start);

  p_start_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    timer_start |-> esc_valid);

  p_hold_until_done_r7: assert property (@(posedge clk) disable iff (rst)
    (esc_valid && !timer_start && !timer_done) |=> esc_valid);

  p_idle_cmd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !esc_valid |-> (esc_cmd == MV_STOP));

  p_escape_is_turn_r8: assert property (@(posedge clk) disable iff (rst)
    esc_valid |-> (is_right_turn(esc_cmd) || is_left_turn(esc_cmd)));

  p_cmd_held_r8: assert property (@(posedge clk) disable iff (rst)
    (esc_valid && !clear) |=> $stable(esc_cmd));

endmodule

// File: tb/loopesc_top_tb_top.sv
module loopesc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd_in = 3'd0;
  logic       cmd_strobe = 1'b0;
  logic       timer_done = 1'b0;
  logic [2:0] esc_cmd;
  logic       esc_valid, timer_start;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit seen[8];

  always #2 clk = ~clk;

  loopesc_top dut_i (
    .clk(clk), .rst(rst), .cmd_in(cmd_in), .cmd_strobe(cmd_strobe),
    .timer_done(timer_done), .esc_cmd(esc_cmd), .esc_valid(esc_valid),
    .timer_start(timer_start)
  );

  // Behavioural reference model, advanced on every rising edge.
  int       m_cnt = 0, m_phase = 0, m_free = 0;
  bit       m_right = 0;
  bit [2:0] m_cmd = 3'd0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; m_phase = 0; m_free = 0; m_right = 0; m_cmd = 3'd0;
    end else begin
      if (m_phase == 0) begin
        if (cmd_strobe) begin
          bit r, l;
          r = (cmd_in == 3'd3) || (cmd_in == 3'd5);
          l = (cmd_in == 3'd4) || (cmd_in == 3'd6);
          if (r || l) begin
            if (m_cnt > 0 && m_right == r) m_cnt++;
            else begin m_cnt = 1; m_right = r; end
            if (m_cnt == 5) begin
              m_phase = 1; m_cnt = 0;
              if (m_right) m_cmd = (m_free % 2) ? 3'd6 : 3'd4;
              else         m_cmd = (m_free % 2) ? 3'd5 : 3'd3;
            end
          end else m_cnt = 0;
        end
      end else if (m_phase == 1) m_phase = 2;
      else if (timer_done) begin m_phase = 0; m_cmd = 3'd0; end
      m_free = (m_free + 1) % 4;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Cycle compare against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      check("R8", esc_cmd, m_cmd);
      check("R7", esc_valid, m_phase != 0);
      check("R6", timer_start, m_phase == 1);
      if (esc_valid) seen[esc_cmd] = 1'b1;
    end
  end

  task automatic strobe(input logic [2:0] c);
    @(negedge clk);
    cmd_in = c; cmd_strobe = 1'b1;
    @(negedge clk);
    cmd_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_escape();
    idle(3);
    timer_done = 1'b1;
    @(negedge clk);
    timer_done = 1'b0;
  endtask

  initial begin
    idle(3);
    check("R1", esc_cmd, 0); check("R1", esc_valid, 0); check("R1", timer_start, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", esc_valid, 0);

    // R2: left loop of mixed rotates and pivots, exactly five needed.
    strobe(3'd4); strobe(3'd6); strobe(3'd4); strobe(3'd6);
    check("R2", esc_valid, 0);
    strobe(3'd4);
    check("R6", timer_start, 1); check("R6", esc_valid, 1);
    check("R8", (esc_cmd == 3'd3 || esc_cmd == 3'd5), 1);
    // R7: done during the start cycle is ignored.
    timer_done = 1'b1;
    @(negedge clk);
    timer_done = 1'b0;
    check("R7", esc_valid, 1); check("R6", timer_start, 0);
    finish_escape();
    check("R7", esc_valid, 0); check("R9", esc_cmd, 0);

    // R3: unstrobed turns between strobes have no effect.
    strobe(3'd3); strobe(3'd5); strobe(3'd3); strobe(3'd5);
    cmd_in = 3'd5; idle(6);
    check("R3", esc_valid, 0);
    strobe(3'd3);
    check("R3", esc_valid, 1);
    check("R8", (esc_cmd == 3'd4 || esc_cmd == 3'd6), 1);
    finish_escape();

    // R4: opposite turn restarts at one.
    strobe(3'd3); strobe(3'd3); strobe(3'd3); strobe(3'd3);
    strobe(3'd4); strobe(3'd4); strobe(3'd4); strobe(3'd4);
    check("R4", esc_valid, 0);
    strobe(3'd6);
    check("R4", esc_valid, 1);
    finish_escape();

    // R5: forward and brake clear the run.
    strobe(3'd5); strobe(3'd5); strobe(3'd5); strobe(3'd5);
    strobe(3'd1);
    strobe(3'd5); strobe(3'd5); strobe(3'd5); strobe(3'd5);
    strobe(3'd7);
    strobe(3'd5); strobe(3'd5); strobe(3'd5); strobe(3'd5);
    check("R5", esc_valid, 0);
    strobe(3'd5);
    check("R5", esc_valid, 1);

    // R10: strobes during the escape are ignored.
    idle(1);
    strobe(3'd3); strobe(3'd3); strobe(3'd3);
    finish_escape();
    strobe(3'd3); strobe(3'd3); strobe(3'd3); strobe(3'd3);
    check("R10", esc_valid, 0);
    strobe(3'd3);
    check("R10", esc_valid, 1);
    finish_escape();

    // R8: sweep the counter phase for both loop directions.
    for (int k = 0; k < 4; k++) begin
      idle(k);
      for (int j = 0; j < 5; j++) strobe((k % 2) ? 3'd3 : 3'd4);
      finish_escape();
      idle(k);
      for (int j = 0; j < 5; j++) strobe((k % 2) ? 3'd6 : 3'd5);
      finish_escape();
    end
    check("R8", seen[3] && seen[4] && seen[5] && seen[6], 1);

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    errors++;
    $display("FAIL watchdog actual %0d expected 0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule